// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor with Index-Addressed Enables

This block gathers level-sensitive interrupt sources and hands them to a small set of CPUs. Software controls it through one register space. The global part holds the distributor enable, a routing control word for each source, and a pair of command registers. Writing a source number to one of these registers enables that shared source, and writing it to the other disables it. Because a command names one source, it cannot disturb any other source, so software never has to read, modify and write back a mask word.

Each CPU has its own register window. The low-numbered sources are private to each CPU. A CPU masks and unmasks them with its own pair of source-number command registers. The window also holds a cause view of the pending sources that are routed to that CPU, and a local-event mask. Each CPU gets one interrupt line. That line rises when a routed pending source is allowed through, or when an unmasked local event is present.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the distributor is off, every shared source is disabled, every private source is masked for every CPU, all routing bits are zero, every `cpu_irq` line is low and `bus_rdata` is zero.
- R2: Writing 0x0000 sets the distributor enable to bit 0 of the write data. A read of 0x0000 returns the enable in bit 0 and NUM_SRC in bits [11:2]. All other bits read as zero.
- R3: Writing N (taken from write data bits [9:0]) to 0x0030 enables shared source N. Writing N to 0x0034 disables it. No other source changes.
- R4: The control word of source N is at 0x0100 + 4*N. Its bit c and bit c+8 are the two routing bits for CPU c, for c < NUM_CPUS. All other bits are not stored and read as zero. A source is routed to CPU c when either of those bits is set.
- R5: The window of CPU c starts at 0x1000 + 0x100*c. In that window, writing N (N < 32) to offset 0x48 masks private source N for that CPU only, and writing N to 0x4C unmasks it.
- R6: Cause word k of CPU c is at window offset 0x10 + 4*k. Its bit j is 1 exactly when source 32*k+j is pending and routed to CPU c. Enable and mask state do not affect it.
- R7: `cpu_irq[c]` is registered. One cycle after its inputs change, it is high exactly when the distributor is enabled and either of these holds: a pending source routed to CPU c is allowed through (an enabled shared source, or a private source that CPU c has left unmasked), or `local_evt[c]` is high while bit c of CPU c's local mask is set.
- R8: The local mask sits at window offset 0x54. Its NUM_CPUS bits can be written and read back. Only bit c gates `local_evt[c]`.
- R9: These command writes are ignored: an enable or disable with N below 32 or N at or above NUM_SRC, and a mask or unmask with N of 32 or more.
- R10: `bus_rdata` shows the register that was addressed in the previous cycle. Addresses with no register, the two enable command registers, and control words of sources at or above NUM_SRC read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| src_pending | input | NUM_SRC | Level of each interrupt source |
| local_evt | input | NUM_CPUS | Local event request of each CPU |
| cpu_irq | output | NUM_CPUS | Interrupt line of each CPU |

## Verification
The assertions assume that `bus_we` is low while reset is applied and that `bus_addr` holds one value for the whole cycle, so that the decoded command and the registered read data line up with the following edge. The bench changes the bus and the source levels only on falling edges and drops the write strobe one cycle after raising it. It checks interrupt lines and read data only after enough edges for the state register and the output register to settle. Some writes are meant to be ignored, for example a mask command whose number aliases to a real private source modulo 32. The bench checks these through the interrupt lines, which would move if the write had taken effect.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int IDX_W = 10;

    // global region offsets (addr[15:12] == 0)
    localparam logic [11:0] OFF_CTRL   = 12'h000;
    localparam logic [11:0] OFF_SET_EN = 12'h030;
    localparam logic [11:0] OFF_CLR_EN = 12'h034;
    localparam int          ROUTE_WORD0 = 64;   // 0x100 / 4

    // per-CPU window offsets (addr[15:12] == 1, addr[11:8] = cpu)
    localparam logic [3:0]  CPU_REGION  = 4'h1;
    localparam int          CAUSE_BASE  = 16'h10;
    localparam logic [7:0]  OFF_SET_MSK = 8'h48;
    localparam logic [7:0]  OFF_CLR_MSK = 8'h4C;
    localparam logic [7:0]  OFF_LMASK   = 8'h54;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_CTRL,
        WR_SET_EN,
        WR_CLR_EN,
        WR_ROUTE,
        WR_SET_MSK,
        WR_CLR_MSK,
        WR_LMASK
    } wr_op_e;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_CTRL,
        RD_ROUTE,
        RD_CAUSE,
        RD_LMASK
    } rd_sel_e;

    typedef struct packed {
        wr_op_e           wr_op;
        rd_sel_e          rd_sel;
        logic [3:0]       cpu;
        logic [IDX_W-1:0] src;
        logic [4:0]       word;
    } dec_t;

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_SRC   = 64,
    parameter int NUM_WORDS = 2
) (
    input  logic [15:0] addr,
    input  logic        we,
    output dec_t        dec
);

    logic [IDX_W-1:0] route_idx;
    logic [4:0]       word_idx;
    logic             in_cpu;
    logic             cause_hit;

    always_comb begin
        route_idx = addr[11:2] - IDX_W'(ROUTE_WORD0);
        word_idx  = addr[6:2] - 5'd4;
        in_cpu    = (addr[15:12] == CPU_REGION) && (int'(addr[11:8]) < NUM_CPUS);
        cause_hit = (int'(addr[7:0]) >= CAUSE_BASE)
                 && (int'(addr[7:0]) < CAUSE_BASE + 4 * NUM_WORDS)
                 && (addr[1:0] == 2'b00);

        dec        = '0;
        dec.wr_op  = WR_NONE;
        dec.rd_sel = RD_ZERO;
        dec.cpu    = addr[11:8];
        dec.src    = route_idx;
        dec.word   = word_idx;

        if (addr[15:12] == 4'h0) begin
            if (addr[11:0] == OFF_CTRL) begin
                dec.rd_sel = RD_CTRL;
                if (we) dec.wr_op = WR_CTRL;
            end else if (addr[11:0] == OFF_SET_EN) begin
                if (we) dec.wr_op = WR_SET_EN;
            end else if (addr[11:0] == OFF_CLR_EN) begin
                if (we) dec.wr_op = WR_CLR_EN;
            end else if (addr[11:8] != 4'h0 && addr[1:0] == 2'b00
                         && int'(route_idx) < NUM_SRC) begin
                dec.rd_sel = RD_ROUTE;
                if (we) dec.wr_op = WR_ROUTE;
            end
        end else if (in_cpu) begin
            if (cause_hit) begin
                dec.rd_sel = RD_CAUSE;
            end else if (addr[7:0] == OFF_SET_MSK) begin
                if (we) dec.wr_op = WR_SET_MSK;
            end else if (addr[7:0] == OFF_CLR_MSK) begin
                if (we) dec.wr_op = WR_CLR_MSK;
            end else if (addr[7:0] == OFF_LMASK) begin
                dec.rd_sel = RD_LMASK;
                if (we) dec.wr_op = WR_LMASK;
            end
        end
    end

endmodule

// File: rtl/irqd_state.sv
module irqd_state
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int NUM_SRC  = 64,
    parameter int PRIV_SRC = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  dec_t                                   dec,
    input  logic [31:0]                            wdata,
    output logic                                   dist_en,
    output logic [NUM_SRC-1:0]                     src_en,
    output logic [NUM_CPUS-1:0][PRIV_SRC-1:0]      priv_msk,
    output logic [NUM_SRC-1:0][2*NUM_CPUS-1:0]     route,
    output logic [NUM_CPUS-1:0][NUM_CPUS-1:0]      lmask
);

    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int CPU_W  = $clog2(NUM_CPUS);
    localparam int PRIV_W = $clog2(PRIV_SRC);
    localparam int RT_W   = 2 * NUM_CPUS;

    typedef struct packed {
        logic                                dist_en;
        logic [NUM_SRC-1:0]                  en;
        logic [NUM_CPUS-1:0][PRIV_SRC-1:0]   msk;
        logic [NUM_SRC-1:0][RT_W-1:0]        route;
        logic [NUM_CPUS-1:0][NUM_CPUS-1:0]   lmask;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]  num;
    logic              shared_ok;
    logic              priv_ok;
    logic [CPU_W-1:0]  cpu;
    logic [SRC_W-1:0]  rsrc;
    logic [SRC_W-1:0]  nsrc;
    logic [PRIV_W-1:0] npriv;

    always_comb begin
        num       = wdata[IDX_W-1:0];
        shared_ok = (int'(num) >= PRIV_SRC) && (int'(num) < NUM_SRC);
        priv_ok   = int'(num) < PRIV_SRC;
        cpu       = dec.cpu[CPU_W-1:0];
        rsrc      = dec.src[SRC_W-1:0];
        nsrc      = num[SRC_W-1:0];
        npriv     = num[PRIV_W-1:0];

        st_d = st_q;
        case (dec.wr_op)
            WR_CTRL:    st_d.dist_en = wdata[0];
            WR_SET_EN:  if (shared_ok) st_d.en[nsrc] = 1'b1;
            WR_CLR_EN:  if (shared_ok) st_d.en[nsrc] = 1'b0;
            WR_ROUTE: begin
                for (int c = 0; c < NUM_CPUS; c++) begin
                    st_d.route[rsrc][c]          = wdata[c];
                    st_d.route[rsrc][NUM_CPUS+c] = wdata[8+c];
                end
            end
            WR_SET_MSK: if (priv_ok) st_d.msk[cpu][npriv] = 1'b1;
            WR_CLR_MSK: if (priv_ok) st_d.msk[cpu][npriv] = 1'b0;
            WR_LMASK:   st_d.lmask[cpu] = wdata[NUM_CPUS-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.msk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dist_en  = st_q.dist_en;
    assign src_en   = st_q.en;
    assign priv_msk = st_q.msk;
    assign route    = st_q.route;
    assign lmask    = st_q.lmask;

    logic unused_bits;
    assign unused_bits = ^{wdata[31:16], dec.rd_sel, dec.word, dec.cpu, dec.src};

    assert_set_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_op == WR_SET_EN && shared_ok) |=> st_q.en[$past(nsrc)]);

    assert_clr_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_op == WR_CLR_EN && shared_ok) |=> !st_q.en[$past(nsrc)]);

    assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_op == WR_CLR_MSK && priv_ok) |=> !st_q.msk[$past(cpu)][$past(npriv)]);

    assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec.wr_op == WR_SET_EN || dec.wr_op == WR_CLR_EN) && !shared_ok)
        |=> $stable(st_q.en));

    assert_oob_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec.wr_op == WR_SET_MSK || dec.wr_op == WR_CLR_MSK) && !priv_ok)
        |=> $stable(st_q.msk));

endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
    parameter int NUM_CPUS = 2,
    parameter int NUM_SRC  = 64,
    parameter int PRIV_SRC = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dist_en,
    input  logic [NUM_SRC-1:0]                  src_en,
    input  logic [NUM_CPUS-1:0][PRIV_SRC-1:0]   priv_msk,
    input  logic [NUM_SRC-1:0][2*NUM_CPUS-1:0]  route,
    input  logic [NUM_CPUS-1:0][NUM_CPUS-1:0]   lmask,
    input  logic [NUM_SRC-1:0]                  src_pending,
    input  logic [NUM_CPUS-1:0]                 local_evt,
    output logic [NUM_CPUS-1:0][NUM_SRC-1:0]    cause,
    output logic [NUM_CPUS-1:0]                 cpu_irq
);

    typedef struct packed {
        logic [NUM_CPUS-1:0] irq;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CPUS-1:0][NUM_SRC-1:0] live;
    logic [NUM_CPUS-1:0]              own_lmask;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign own_lmask[c] = lmask[c][c];
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign cause[c][n] = src_pending[n] & (route[n][c] | route[n][NUM_CPUS+c]);
            if (n < PRIV_SRC) begin : g_priv
                assign live[c][n] = ~priv_msk[c][n];
            end else begin : g_shared
                assign live[c][n] = src_en[n];
            end
        end

        assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> $past((|cause[c]) || local_evt[c]));
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CPUS; c++) begin
            st_d.irq[c] = dist_en
                        & ((|(cause[c] & live[c])) | (local_evt[c] & own_lmask[c]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq = st_q.irq;

    logic unused_lmask;
    assign unused_lmask = ^lmask;

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |=> cpu_irq == '0);

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int NUM_SRC  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]  src_pending,
    input  logic [NUM_CPUS-1:0] local_evt,
    output logic [NUM_CPUS-1:0] cpu_irq
);

    localparam int PRIV_SRC  = 32;
    localparam int NUM_WORDS = NUM_SRC / 32;
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CPU_W     = $clog2(NUM_CPUS);
    localparam int SRC_W     = $clog2(NUM_SRC);

    dec_t                               dec;
    logic                               dist_en;
    logic [NUM_SRC-1:0]                 src_en;
    logic [NUM_CPUS-1:0][PRIV_SRC-1:0]  priv_msk;
    logic [NUM_SRC-1:0][2*NUM_CPUS-1:0] route;
    logic [NUM_CPUS-1:0][NUM_CPUS-1:0]  lmask;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0]   cause;

    irqd_decode #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_SRC  (NUM_SRC),
        .NUM_WORDS(NUM_WORDS)
    ) u_decode (
        .addr(bus_addr),
        .we  (bus_we),
        .dec (dec)
    );

    irqd_state #(
        .NUM_CPUS(NUM_CPUS),
        .NUM_SRC (NUM_SRC),
        .PRIV_SRC(PRIV_SRC)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wdata   (bus_wdata),
        .dist_en (dist_en),
        .src_en  (src_en),
        .priv_msk(priv_msk),
        .route   (route),
        .lmask   (lmask)
    );

    irqd_route #(
        .NUM_CPUS(NUM_CPUS),
        .NUM_SRC (NUM_SRC),
        .PRIV_SRC(PRIV_SRC)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .dist_en    (dist_en),
        .src_en     (src_en),
        .priv_msk   (priv_msk),
        .route      (route),
        .lmask      (lmask),
        .src_pending(src_pending),
        .local_evt  (local_evt),
        .cause      (cause),
        .cpu_irq    (cpu_irq)
    );

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [CPU_W-1:0]   cpu;
    logic [SRC_W-1:0]   rsrc;
    logic [WORD_W-1:0]  word;
    logic [NUM_SRC-1:0] cause_sel;

    always_comb begin
        cpu       = dec.cpu[CPU_W-1:0];
        rsrc      = dec.src[SRC_W-1:0];
        word      = dec.word[WORD_W-1:0];
        cause_sel = cause[cpu];

        rd_d.rdata = '0;
        case (dec.rd_sel)
            RD_CTRL: begin
                rd_d.rdata[11:2] = 10'(NUM_SRC);
                rd_d.rdata[0]    = dist_en;
            end
            RD_ROUTE: begin
                for (int c = 0; c < NUM_CPUS; c++) begin
                    rd_d.rdata[c]   = route[rsrc][c];
                    rd_d.rdata[8+c] = route[rsrc][NUM_CPUS+c];
                end
            end
            RD_CAUSE: rd_d.rdata = cause_sel[{word, 5'b0} +: 32];
            RD_LMASK: rd_d.rdata[NUM_CPUS-1:0] = lmask[cpu];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    logic unused_dec;
    assign unused_dec = ^{dec.wr_op, dec.cpu, dec.src, dec.word};

    assert_ctrl_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 16'h0000) |=> bus_rdata[11:2] == 10'(NUM_SRC));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:13] != 3'b000) |=> bus_rdata == '0);

endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 2;
    localparam int NSRC = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       bus_addr = 16'h3000;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   src_pending = '0;
    logic [NCPU-1:0]   local_evt = '0;
    logic [NCPU-1:0]   cpu_irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_distributor #(.NUM_CPUS(NCPU), .NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pending(src_pending), .local_evt(local_evt), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 16'h3000;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        bus_addr = 16'h3000;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic irq_is(input string tag, input logic [NCPU-1:0] exp);
        settle();
        chk(tag, 32'(cpu_irq), 32'(exp));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", 32'(cpu_irq), 0);
        chk("R1 rdata after reset", bus_rdata, 0);
        rd(16'h0000, v); chk("R1 ctrl off, R2 count", v, 32'h0000_0100);
        rd(16'h01A0, v); chk("R1 route zero", v, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(16'h0000, 32'h1);
        rd(16'h0000, v); chk("R2 ctrl enable readback", v, 32'h0000_0101);
    endtask

    task automatic t_shared();
        logic [31:0] v;
        src_pending[40] = 1'b1;
        wr(16'h01A0, 32'h1);
        irq_is("R3 disabled source silent", 2'b00);
        rd(16'h1014, v); chk("R6 cause cpu0 word1", v, 32'h0000_0100);
        rd(16'h1114, v); chk("R6 cause cpu1 unrouted", v, 0);
        wr(16'h0030, 32'd40);
        irq_is("R3 set-enable", 2'b01);
        wr(16'h0030, 32'd41);
        wr(16'h0034, 32'd41);
        irq_is("R3 neighbour unchanged", 2'b01);
        wr(16'h01A0, 32'hFFFF_FFFF);
        rd(16'h01A0, v); chk("R4 route readback", v, 32'h0000_0303);
        irq_is("R4 routed both", 2'b11);
        wr(16'h01A0, 32'h0000_0200);
        irq_is("R4 high bit routes cpu1", 2'b10);
        wr(16'h0034, 32'd104);
        irq_is("R9 oob clear ignored", 2'b10);
        wr(16'h0034, 32'd40);
        irq_is("R3 clear-enable", 2'b00);
    endtask

    task automatic t_private();
        logic [31:0] v;
        src_pending[40] = 1'b0;
        src_pending[5]  = 1'b1;
        wr(16'h0114, 32'h3);
        irq_is("R5 private masked at reset", 2'b00);
        rd(16'h1010, v); chk("R6 cause ignores mask", v, 32'h0000_0020);
        wr(16'h104C, 32'd5);
        irq_is("R5 unmask cpu0 only", 2'b01);
        wr(16'h114C, 32'd5);
        irq_is("R5 unmask cpu1", 2'b11);
        wr(16'h1048, 32'd5);
        irq_is("R5 mask cpu0", 2'b10);
        wr(16'h0030, 32'd5);
        irq_is("R9 set-enable of private ignored", 2'b10);
        wr(16'h1148, 32'd37);
        irq_is("R9 oob mask ignored", 2'b10);
    endtask

    task automatic t_local();
        logic [31:0] v;
        src_pending = '0;
        irq_is("R7 no pending no irq", 2'b00);
        local_evt = 2'b11;
        wr(16'h1054, 32'h2);
        irq_is("R8 foreign lmask bit no effect", 2'b00);
        rd(16'h1054, v); chk("R8 lmask readback", v, 32'h2);
        wr(16'h1054, 32'h1);
        irq_is("R8 own lmask bit", 2'b01);
        wr(16'h1154, 32'h2);
        irq_is("R8 cpu1 lmask", 2'b11);
        wr(16'h0000, 32'h0);
        irq_is("R7 distributor off gates all", 2'b00);
        local_evt = 2'b00;
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(16'h2000, v); chk("R10 unmapped high", v, 0);
        rd(16'h0030, v); chk("R10 set-enable reads zero", v, 0);
        rd(16'h0040, v); chk("R10 unmapped global", v, 0);
        rd(16'h1018, v); chk("R10 cause beyond words", v, 0);
        rd(16'h1210, v); chk("R10 absent cpu window", v, 0);
        rd(16'h0200, v); chk("R10 route beyond sources", v, 0);
        wr(16'h01A0, 32'h0000_0101);
        @(negedge clk);
        bus_addr = 16'h01A0;
        #1 chk("R10 read latency old value", bus_rdata, 0);
        @(negedge clk);
        chk("R10 read latency new value", bus_rdata, 32'h0000_0101);
        bus_addr = 16'h3000;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_shared();
        t_private();
        t_local();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule